// File: doc/BRIEF.md
# Multi-Sector Track Address Sequencer

This block walks through the sector addresses of a disk transfer that spans several sectors. A host-side controller loads a starting cylinder, head and sector, a size code, a last-sector number for the track, a short byte-length value and two mode flags (side continuation and deleted-sector skipping) with one start pulse. From then on, the media logic reports each finished sector with a single-cycle strobe. The sequencer answers with the address of the next sector to look for, or ends the run.

While a run is active the block presents the current cylinder, head and sector, the head select, and the number of bytes each sector carries. It also presents a data-transfer enable that drops for sectors marked deleted when skipping is on. When the last sector is done, busy falls and a one-cycle finish pulse marks that the result values are ready. At that point the sector output holds the number that follows the last sector transferred. The block does not search ID fields, check CRC or move data bytes.

Top module: `sector_sequencer`

## Requirements
- R1: After synchronous active-low reset, busy_o, finish_o and xfer_en_o are 0 and cyl_o, head_o, sec_o, size_o and byte_cnt_o are 0.
- R2: A start_i pulse while idle loads cylinder, head, sector, size code, last sector, byte length and both flags, and busy_o is 1 from the next cycle. A start_i pulse while busy changes nothing.
- R3: A sector_done_i strobe while busy, with sec_o different from the loaded last-sector value, makes sec_o one greater on the next cycle (modulo 256), with head unchanged.
- R4: A sector_done_i strobe on the last sector ends the run when side continuation is off or head_o is already 1. On the next cycle busy_o is 0, finish_o is 1 for exactly one cycle, sec_o equals the last-sector value plus one modulo 256, and cylinder, head and size are held.
- R5: A sector_done_i strobe on the last sector with side continuation on and head_o at 0 keeps the run going at head 1, sector 1.
- R6: byte_cnt_o is the loaded byte length when the size code is 0. Otherwise it is 128 shifted left by the size code, with codes above 6 treated as 6 (8192 bytes).
- R7: xfer_en_o is 1 while busy unless skipping is on and deleted_i is 1. A skipped sector still advances the address when it is reported done.
- R8: A sector_done_i strobe while idle leaves every output unchanged.
- R9: cyl_o stays constant for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load parameters and begin a run (only while idle) |
| cyl_i | input | 8 | Starting cylinder |
| head_i | input | 1 | Starting head (side) |
| sec_i | input | 8 | Starting sector number |
| size_i | input | 3 | Sector size code |
| eot_i | input | 8 | Last sector number on the track |
| dtl_i | input | 8 | Bytes per sector when the size code is 0 |
| mt_i | input | 1 | Continue onto side 1 after side 0 |
| skip_i | input | 1 | Skip data of deleted-mark sectors |
| deleted_i | input | 1 | Current sector carries a deleted-data mark |
| sector_done_i | input | 1 | One-cycle strobe: current sector finished |
| busy_o | output | 1 | Run in progress |
| finish_o | output | 1 | One-cycle pulse when the run ends |
| cyl_o | output | 8 | Current or final cylinder |
| head_o | output | 1 | Current head, also the head select |
| sec_o | output | 8 | Current sector, or the next one after the run ends |
| size_o | output | 3 | Loaded size code |
| byte_cnt_o | output | 14 | Bytes per sector |
| xfer_en_o | output | 1 | Data of the current sector is to be transferred |

## Verification
The assertions check these rules on every cycle: the step from one sector to the next, the stop and its finish pulse, the jump to side 1, the freeze while idle, the constant cylinder, and the rule that the transfer enable only appears during a run. Some behaviour shows only in the bench's swept runs: the full address sequence for many combinations of start sector, last sector, side and continuation flag, the byte-count mapping for every size code, the rejected restart and the wrap of the final sector number past 255.

// File: rtl/secseq_pkg.sv
package secseq_pkg;
    // Kind of step the address takes when a sector is reported done
    typedef enum logic [1:0] {
        STEP_NEXT = 2'd0,   // same side, sector + 1
        STEP_SIDE = 2'd1,   // hop to side 1, sector 1
        STEP_STOP = 2'd2    // last sector reached, run ends
    } step_e;
endpackage

// File: rtl/secseq_bytes.sv
// secseq_bytes: turns a sector size code into a byte count.
// Assumes DTL_W <= CNT_W and that CNT_W can hold 2**(BASE_LOG2+MAX_SIZE).
// Code 0 selects the explicit length; codes above MAX_SIZE saturate.
module secseq_bytes #(
    parameter int SIZE_W    = 3,
    parameter int MAX_SIZE  = 6,
    parameter int BASE_LOG2 = 7,
    parameter int DTL_W     = 8,
    parameter int CNT_W     = BASE_LOG2 + MAX_SIZE + 1
) (
    input  logic [SIZE_W-1:0] size_code,
    input  logic [DTL_W-1:0]  dtl,
    output logic [CNT_W-1:0]  bytes
);
    localparam int SHIFT_W = $clog2(BASE_LOG2 + MAX_SIZE + 1);

    logic [SHIFT_W-1:0] shift_amt;

    // Pick the shift: clamp oversized codes to the largest legal size
    always_comb begin
        if (int'(size_code) > MAX_SIZE)
            shift_amt = SHIFT_W'(BASE_LOG2 + MAX_SIZE);
        else
            shift_amt = SHIFT_W'(BASE_LOG2) + SHIFT_W'(size_code);
    end

    // Final count: explicit length for code 0, power of two otherwise
    always_comb begin
        if (size_code == '0)
            bytes = CNT_W'(dtl);
        else
            bytes = CNT_W'(1) << shift_amt;
    end
endmodule

// File: rtl/secseq_next.sv
// secseq_next: decides where the address goes after the current sector.
// Assumes sectors are numbered from 1 and that side 1 follows side 0 only
// when side continuation is enabled.
module secseq_next
    import secseq_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input  logic [SEC_W-1:0] sec,
    input  logic             head,
    input  logic [SEC_W-1:0] eot,
    input  logic             mt,
    output step_e            step,
    output logic [SEC_W-1:0] next_sec,
    output logic             next_head
);
    // Classify the step from the end-of-track compare and the side
    always_comb begin
        if (sec != eot)
            step = STEP_NEXT;
        else if (mt && !head)
            step = STEP_SIDE;
        else
            step = STEP_STOP;
    end

    // Produce the following address; a stop still shows sector + 1
    always_comb begin
        if (step == STEP_SIDE) begin
            next_sec  = SEC_W'(1);
            next_head = 1'b1;
        end else begin
            next_sec  = sec + SEC_W'(1);
            next_head = head;
        end
    end
endmodule

// File: rtl/sector_sequencer.sv
// sector_sequencer: holds the parameters of a multi-sector run and steps
// the sector address on each sector_done_i strobe until the last sector.
// Assumes sector_done_i is a one-cycle strobe from the media logic and that
// start_i is issued only with valid parameters; start while busy is dropped.
module sector_sequencer
    import secseq_pkg::*;
#(
    parameter int CYL_W     = 8,
    parameter int SEC_W     = 8,
    parameter int SIZE_W    = 3,
    parameter int DTL_W     = 8,
    parameter int MAX_SIZE  = 6,
    parameter int BASE_LOG2 = 7,
    parameter int CNT_W     = BASE_LOG2 + MAX_SIZE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CYL_W-1:0]  cyl_i,
    input  logic              head_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [SEC_W-1:0]  eot_i,
    input  logic [DTL_W-1:0]  dtl_i,
    input  logic              mt_i,
    input  logic              skip_i,
    input  logic              deleted_i,
    input  logic              sector_done_i,
    output logic              busy_o,
    output logic              finish_o,
    output logic [CYL_W-1:0]  cyl_o,
    output logic              head_o,
    output logic [SEC_W-1:0]  sec_o,
    output logic [SIZE_W-1:0] size_o,
    output logic [CNT_W-1:0]  byte_cnt_o,
    output logic              xfer_en_o
);
    logic [CYL_W-1:0]  cyl_q;
    logic              head_q;
    logic [SEC_W-1:0]  sec_q;
    logic [SIZE_W-1:0] size_q;
    logic [SEC_W-1:0]  eot_q;
    logic [DTL_W-1:0]  dtl_q;
    logic              mt_q;
    logic              skip_q;
    logic              busy_q;
    logic              fin_q;

    step_e             step;
    logic [SEC_W-1:0]  nxt_sec;
    logic              nxt_head;

    secseq_next #(.SEC_W(SEC_W)) u_next (
        .sec       (sec_q),
        .head      (head_q),
        .eot       (eot_q),
        .mt        (mt_q),
        .step      (step),
        .next_sec  (nxt_sec),
        .next_head (nxt_head)
    );

    secseq_bytes #(
        .SIZE_W    (SIZE_W),
        .MAX_SIZE  (MAX_SIZE),
        .BASE_LOG2 (BASE_LOG2),
        .DTL_W     (DTL_W),
        .CNT_W     (CNT_W)
    ) u_bytes (
        .size_code (size_q),
        .dtl       (dtl_q),
        .bytes     (byte_cnt_o)
    );

    // Load parameters on start, then step the address on each done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_q  <= '0;
            head_q <= 1'b0;
            sec_q  <= '0;
            size_q <= '0;
            eot_q  <= '0;
            dtl_q  <= '0;
            mt_q   <= 1'b0;
            skip_q <= 1'b0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!busy_q && start_i) begin
                cyl_q  <= cyl_i;
                head_q <= head_i;
                sec_q  <= sec_i;
                size_q <= size_i;
                eot_q  <= eot_i;
                dtl_q  <= dtl_i;
                mt_q   <= mt_i;
                skip_q <= skip_i;
                busy_q <= 1'b1;
            end else if (busy_q && sector_done_i) begin
                sec_q  <= nxt_sec;
                head_q <= nxt_head;
                if (step == STEP_STOP) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    // Drive outputs from the held state
    always_comb begin
        busy_o    = busy_q;
        finish_o  = fin_q;
        cyl_o     = cyl_q;
        head_o    = head_q;
        sec_o     = sec_q;
        size_o    = size_q;
        xfer_en_o = busy_q && !(skip_q && deleted_i);
    end
endmodule

// File: rtl/sector_sequencer_chk.sv
// sector_sequencer_chk: cycle-by-cycle rules for the sector sequencer.
// Assumes it is bound to sector_sequencer and sees its held last-sector
// value and continuation flag.
module sector_sequencer_chk #(
    parameter int CYL_W = 8,
    parameter int SEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             sector_done_i,
    input logic             busy_o,
    input logic             finish_o,
    input logic [CYL_W-1:0] cyl_o,
    input logic             head_o,
    input logic [SEC_W-1:0] sec_o,
    input logic             xfer_en_o,
    input logic [SEC_W-1:0] eot_q,
    input logic             mt_q
);
    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sector_done_i && sec_o != eot_q)
        |=> (busy_o && sec_o == SEC_W'($past(sec_o) + 1'b1) && head_o == $past(head_o))); // R3

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sector_done_i && sec_o == eot_q && !(mt_q && !head_o))
        |=> (!busy_o && finish_o && $stable(head_o) && $stable(cyl_o))); // R4

    AST_FINISH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !finish_o); // R4

    AST_SIDE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sector_done_i && sec_o == eot_q && mt_q && !head_o)
        |=> (busy_o && head_o && sec_o == SEC_W'(1))); // R5

    AST_XFER_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en_o |-> busy_o); // R7

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i)
        |=> ($stable(sec_o) && $stable(head_o) && $stable(cyl_o) && !busy_o)); // R8

    AST_CYL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish_o) |=> $stable(cyl_o)); // R9
endmodule

bind sector_sequencer sector_sequencer_chk #(.CYL_W(CYL_W), .SEC_W(SEC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .sector_done_i (sector_done_i),
    .busy_o        (busy_o),
    .finish_o      (finish_o),
    .cyl_o         (cyl_o),
    .head_o        (head_o),
    .sec_o         (sec_o),
    .xfer_en_o     (xfer_en_o),
    .eot_q         (eot_q),
    .mt_q          (mt_q)
);

// File: tb/sector_sequencer_bench.sv
module sector_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  cyl_i = '0;
    logic        head_i = 1'b0;
    logic [7:0]  sec_i = '0;
    logic [2:0]  size_i = '0;
    logic [7:0]  eot_i = '0;
    logic [7:0]  dtl_i = '0;
    logic        mt_i = 1'b0;
    logic        skip_i = 1'b0;
    logic        deleted_i = 1'b0;
    logic        sector_done_i = 1'b0;
    logic        busy_o, finish_o, head_o, xfer_en_o;
    logic [7:0]  cyl_o, sec_o;
    logic [2:0]  size_o;
    logic [13:0] byte_cnt_o;

    int checks = 0;
    int errors = 0;

    sector_sequencer u_sector_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cyl_i(cyl_i),
        .head_i(head_i), .sec_i(sec_i), .size_i(size_i), .eot_i(eot_i),
        .dtl_i(dtl_i), .mt_i(mt_i), .skip_i(skip_i), .deleted_i(deleted_i),
        .sector_done_i(sector_done_i), .busy_o(busy_o), .finish_o(finish_o),
        .cyl_o(cyl_o), .head_o(head_o), .sec_o(sec_o), .size_o(size_o),
        .byte_cnt_o(byte_cnt_o), .xfer_en_o(xfer_en_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_run(input int c, input int h, input int s, input int sz,
                             input int e, input int d, input int mt, input int sk);
        @(negedge clk);
        cyl_i = 8'(c); head_i = 1'(h); sec_i = 8'(s); size_i = 3'(sz);
        eot_i = 8'(e); dtl_i = 8'(d); mt_i = 1'(mt); skip_i = 1'(sk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic pulse_done();
        sector_done_i = 1'b1;
        @(negedge clk);
        sector_done_i = 1'b0;
    endtask

    // Full run with an arithmetic model of the address sequence
    task automatic sweep_run(input int c, input int h, input int s, input int e, input int mt);
        int es = s;
        int eh = h;
        bit running = 1'b1;
        start_run(c, h, s, 1, e, 0, mt, 0);
        check("R2 busy after start", int'(busy_o), 1);
        for (int step = 0; step < 600 && running; step++) begin
            check("R3 sector", int'(sec_o), es);
            check("R5 head", int'(head_o), eh);
            pulse_done();
            if (es == e) begin
                if (mt != 0 && eh == 0) begin
                    eh = 1; es = 1;
                end else begin
                    es = (e + 1) % 256;
                    running = 1'b0;
                end
            end else begin
                es = (es + 1) % 256;
            end
            check("R9 cylinder", int'(cyl_o), c);
        end
        check("R4 busy low", int'(busy_o), 0);
        check("R4 finish pulse", int'(finish_o), 1);
        check("R4 final sector", int'(sec_o), es);
        check("R4 final head", int'(head_o), eh);
        @(negedge clk);
        check("R4 finish one cycle", int'(finish_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy_o), 0);
        check("R1 finish", int'(finish_o), 0);
        check("R1 xfer", int'(xfer_en_o), 0);
        check("R1 sector", int'(sec_o), 0);
        check("R1 cylinder", int'(cyl_o), 0);
        check("R1 bytes", int'(byte_cnt_o), 0);
        rst_n = 1'b1;

        // R3 R4 R5: sweep start/last sector, side and continuation
        for (int mt = 0; mt < 2; mt++)
            for (int h = 0; h < 2; h++)
                for (int e = 1; e <= 5; e++)
                    for (int s = 1; s <= e; s++)
                        sweep_run(10 + e, h, s, e, mt);

        // R4: final sector number wraps past 255
        sweep_run(3, 0, 254, 255, 0);

        // R6: byte count for every size code
        for (int sz = 0; sz < 8; sz++) begin
            int exp;
            start_run(1, 0, 1, sz, 1, 77, 0, 0);
            exp = (sz == 0) ? 77 : (128 << ((sz > 6) ? 6 : sz));
            check("R6 byte count", int'(byte_cnt_o), exp);
            check("R2 size code", int'(size_o), sz);
            pulse_done();
        end

        // R2: start while busy is ignored
        start_run(20, 0, 2, 2, 4, 0, 0, 0);
        start_run(99, 1, 7, 5, 9, 0, 1, 0);
        check("R2 restart cyl", int'(cyl_o), 20);
        check("R2 restart sec", int'(sec_o), 2);
        check("R2 restart head", int'(head_o), 0);
        check("R2 restart size", int'(size_o), 2);
        pulse_done(); pulse_done();
        check("R2 restart eot kept", int'(busy_o), 1);
        pulse_done();
        check("R2 ends at kept eot", int'(busy_o), 0);

        // R8: done strobe while idle changes nothing
        pulse_done();
        check("R8 idle sector", int'(sec_o), 5);
        check("R8 idle busy", int'(busy_o), 0);
        check("R8 idle finish", int'(finish_o), 0);

        // R7: deleted-sector skip gates transfer but still advances
        start_run(4, 0, 1, 1, 3, 0, 0, 1);
        deleted_i = 1'b1;
        #1 check("R7 skip gated", int'(xfer_en_o), 0);
        pulse_done();
        deleted_i = 1'b0;
        check("R7 skipped sector advances", int'(sec_o), 2);
        #1 check("R7 normal sector enabled", int'(xfer_en_o), 1);
        pulse_done(); pulse_done();
        start_run(4, 0, 1, 1, 1, 0, 0, 0);
        deleted_i = 1'b1;
        #1 check("R7 no skip keeps data", int'(xfer_en_o), 1);
        deleted_i = 1'b0;
        pulse_done();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule